// File: doc/BRIEF.md
# Dual-Channel Packet DMA Control Register Block

This block is the host-visible register set of a two-channel packet-DMA disk controller. A simple synchronous host bus reads and writes byte-addressed registers. For every channel the block keeps an interrupt mask, a PIO timing mode, a packet count, a next-packet pointer and two FIFO thresholds. It drives these values to the packet engine and turns command bits in the channel control word into single-cycle pulses for engine reset and packet start.

The engine reports events as set pulses on an 8-bit status vector per channel. The block collects these events into sticky status bits, which a host read returns and clears in the same access. From them it drives a per-channel failure flag and a maskable interrupt. A global key byte must hold the value 7 before any start command reaches the engine. Until then, start requests are dropped.

Top module: `pdma_regfile`

## Requirements
- R1: After reset, each channel reads control 0x0100 (interrupt masked, PIO mode 0), status 0, packet count 1, next pointer 0, and both FIFO thresholds 0x0100. The key byte reads 0, and all pulses, interrupts and failure flags are low.
- R2: Channel n occupies byte addresses 0x80 + n*0x20 up to 0x9F + n*0x20. Within a channel, control is at offset 0x00 (16 bit), status at 0x02 (8 bit), packet count at 0x04 (16 bit), next pointer at 0x0C (32 bit), input threshold at 0x14 (16 bit) and output threshold at 0x16 (16 bit). Writes take the low bits of the write data. A read returns the value zero-extended on host_rdata in the cycle after host_rd, and any other address reads 0.
- R3: Control bit 8 (interrupt mask, 1 = masked) and bits 1:0 (PIO mode) are held and read back. Every other control bit reads 0.
- R4: A control write with bit 5 set drives that channel's eng_reset high for exactly the one cycle following the write edge.
- R5: A control write with bit 7 set drives eng_start high for the one cycle following the write edge, but only when bit 5 is clear in the same write and the key byte held 7 before that write.
- R6: The key byte sits at address 0xC7, resets to 0 and reads back as written. While it does not hold 7, a start write produces no pulse.
- R7: Engine event bits are ORed into the sticky status register. A status read returns the bits held before the access and clears them. An event arriving in the same cycle as the read is kept and is not part of the returned value. Host writes to status have no effect.
- R8: irq[n] is high exactly when channel n's status is nonzero and its mask bit is 0.
- R9: ch_err[n] is high exactly when any of status bits 6, 4 or 0 is set.
- R10: The PIO mode, packet count, next pointer and thresholds are driven on the configuration outputs, changing in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid the cycle after host_rd |
| eng_evt | input | 16 | Engine status set pulses, 8 per channel |
| eng_start | output | 2 | Packet start pulse per channel |
| eng_reset | output | 2 | Engine reset pulse per channel |
| irq | output | 2 | Masked interrupt per channel |
| ch_err | output | 2 | Packet failure flag per channel |
| cfg_pio | output | 4 | PIO mode, 2 bits per channel |
| cfg_pkt_cnt | output | 32 | Packet count, 16 bits per channel |
| cfg_next_ptr | output | 64 | Next-packet pointer, 32 bits per channel |
| cfg_fifo_in | output | 32 | Input FIFO threshold, 16 bits per channel |
| cfg_fifo_out | output | 32 | Output FIFO threshold, 16 bits per channel |

## Verification
Two functions can fall in the same cycle. A host read-to-clear of status can coincide with a new engine event on the same channel, and a single control write can carry both the reset and the start command. The bench provokes the first directly, by driving an event in the very cycle of a status read. The random phase then repeats this collision many times. The read must return only the older bits, and a second read must show the new event. For the second collision, a write with both command bits set must yield a reset pulse and no start pulse, even with the key set to 7.

// File: rtl/pdma_regs_pkg.sv
// Shared constants for the dual-channel packet DMA register block.
// Assumes byte addressing with an 8-bit address and 32-bit data.
package pdma_regs_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int OFS_W     = 5;
    localparam int EVT_W     = 8;

    localparam logic [ADDR_W-1:0] CH_BASE   = 8'h80;
    localparam int                CH_STRIDE = 32;
    localparam logic [ADDR_W-1:0] KEY_ADDR  = 8'hC7;
    localparam logic [7:0]        KEY_VALUE = 8'h07;

    localparam logic [OFS_W-1:0] OFS_CTL  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_STAT = 5'h02;
    localparam logic [OFS_W-1:0] OFS_CNT  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_PTR  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_FIN  = 5'h14;
    localparam logic [OFS_W-1:0] OFS_FOUT = 5'h16;

    localparam int CTL_MASK_BIT = 8;
    localparam int CTL_GO_BIT   = 7;
    localparam int CTL_RST_BIT  = 5;

    localparam logic [EVT_W-1:0] STAT_ERR_MASK = 8'h51;

    localparam logic [15:0] RST_FIFO_THR = 16'h0100;
    localparam logic [15:0] RST_PKT_CNT  = 16'h0001;
endpackage

// File: rtl/pdma_decode.sv
// Address decoder: splits a host byte address into a one-hot channel
// select, an in-channel offset and a key-register hit.
// Assumes channel blocks are CH_STRIDE bytes and aligned to that size.
module pdma_decode
    import pdma_regs_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    ch_sel,
    output logic [OFS_W-1:0]  ofs,
    output logic              key_sel
);
    localparam int BLK_W = ADDR_W - OFS_W;

    // Offset inside a channel block is the low address bits.
    assign ofs     = addr[OFS_W-1:0];
    assign key_sel = (addr == KEY_ADDR);

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        localparam int          BASE_I = int'(CH_BASE) + i * CH_STRIDE;
        localparam logic [BLK_W-1:0] BLK = BLK_W'(BASE_I >> OFS_W);
        // Channel i is selected when the upper address bits match its block.
        assign ch_sel[i] = (addr[ADDR_W-1:OFS_W] == BLK);
    end
endmodule

// File: rtl/pdma_key.sv
// Global key byte that gates packet start commands.
// Assumes the key is written as a whole byte; only the value 7 unlocks.
module pdma_key
    import pdma_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    output logic [7:0] key_q,
    output logic       unlocked
);
    // Hold the last byte written to the key address.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (wr_hit) key_q <= wdata;
    end

    assign unlocked = (key_q == KEY_VALUE);
endmodule

// File: rtl/pdma_chan.sv
// One channel's register set: held configuration, command pulses,
// sticky read-to-clear status, interrupt and failure flags.
// Assumes wr_hit/rd_hit are already qualified by this channel's select.
module pdma_chan
    import pdma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_ok,
    input  logic [EVT_W-1:0]  evt,
    output logic [DATA_W-1:0] rdata,
    output logic              start_p,
    output logic              reset_p,
    output logic              irq,
    output logic              err,
    output logic [1:0]        pio,
    output logic [15:0]       pkt_cnt,
    output logic [31:0]       next_ptr,
    output logic [15:0]       fifo_in,
    output logic [15:0]       fifo_out
);
    logic             mask_q;
    logic [EVT_W-1:0] stat_q;
    logic             wr_ctl;
    logic             rd_stat;

    assign wr_ctl  = wr_hit && (ofs == OFS_CTL);
    assign rd_stat = rd_hit && (ofs == OFS_STAT);

    // Held configuration fields, loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= 1'b1;
            pio      <= '0;
            pkt_cnt  <= RST_PKT_CNT;
            next_ptr <= '0;
            fifo_in  <= RST_FIFO_THR;
            fifo_out <= RST_FIFO_THR;
        end else if (wr_hit) begin
            case (ofs)
                OFS_CTL: begin
                    mask_q <= wdata[CTL_MASK_BIT];
                    pio    <= wdata[1:0];
                end
                OFS_CNT:  pkt_cnt  <= wdata[15:0];
                OFS_PTR:  next_ptr <= wdata;
                OFS_FIN:  fifo_in  <= wdata[15:0];
                OFS_FOUT: fifo_out <= wdata[15:0];
                default:  ;
            endcase
        end
    end

    // Self-clearing command pulses; reset suppresses a start in the same write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_p <= 1'b0;
            start_p <= 1'b0;
        end else begin
            reset_p <= wr_ctl && wdata[CTL_RST_BIT];
            start_p <= wr_ctl && wdata[CTL_GO_BIT] && !wdata[CTL_RST_BIT] && start_ok;
        end
    end

    // Sticky status: events set bits, a status read clears older bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (rd_stat ? '0 : stat_q) | evt;
    end

    // Read-back value for the addressed register.
    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_CTL:  rdata = {23'b0, mask_q, 6'b0, pio};
            OFS_STAT: rdata = {24'b0, stat_q};
            OFS_CNT:  rdata = {16'b0, pkt_cnt};
            OFS_PTR:  rdata = next_ptr;
            OFS_FIN:  rdata = {16'b0, fifo_in};
            OFS_FOUT: rdata = {16'b0, fifo_out};
            default:  rdata = '0;
        endcase
    end

    assign irq = !mask_q && (|stat_q);
    assign err = |(stat_q & STAT_ERR_MASK);
endmodule

// File: rtl/pdma_regfile.sv
// Top of the dual-channel packet DMA register block: decode, key byte,
// one register set per channel and the registered read-data path.
// Assumes one host access per cycle; read data lands one cycle later.
module pdma_regfile
    import pdma_regs_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    input  logic [NCH*EVT_W-1:0]  eng_evt,
    output logic [NCH-1:0]        eng_start,
    output logic [NCH-1:0]        eng_reset,
    output logic [NCH-1:0]        irq,
    output logic [NCH-1:0]        ch_err,
    output logic [NCH*2-1:0]      cfg_pio,
    output logic [NCH*16-1:0]     cfg_pkt_cnt,
    output logic [NCH*32-1:0]     cfg_next_ptr,
    output logic [NCH*16-1:0]     cfg_fifo_in,
    output logic [NCH*16-1:0]     cfg_fifo_out
);
    logic [NCH-1:0]    ch_sel;
    logic [OFS_W-1:0]  ofs;
    logic              key_sel;
    logic [7:0]        lock_val;
    logic              unlocked;
    logic [DATA_W-1:0] ch_rdata [NCH];
    logic [DATA_W-1:0] rd_mux;

    pdma_decode #(.NCH(NCH)) u_dec (
        .addr    (host_addr),
        .ch_sel  (ch_sel),
        .ofs     (ofs),
        .key_sel (key_sel)
    );

    pdma_key u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (host_wr && key_sel),
        .wdata    (host_wdata[7:0]),
        .key_q    (lock_val),
        .unlocked (unlocked)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pdma_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (host_wr && ch_sel[i]),
            .rd_hit   (host_rd && ch_sel[i]),
            .ofs      (ofs),
            .wdata    (host_wdata),
            .start_ok (unlocked),
            .evt      (eng_evt[i*EVT_W +: EVT_W]),
            .rdata    (ch_rdata[i]),
            .start_p  (eng_start[i]),
            .reset_p  (eng_reset[i]),
            .irq      (irq[i]),
            .err      (ch_err[i]),
            .pio      (cfg_pio[i*2 +: 2]),
            .pkt_cnt  (cfg_pkt_cnt[i*16 +: 16]),
            .next_ptr (cfg_next_ptr[i*32 +: 32]),
            .fifo_in  (cfg_fifo_in[i*16 +: 16]),
            .fifo_out (cfg_fifo_out[i*16 +: 16])
        );
    end

    // Select read data from the addressed channel or the key byte.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel[i]) rd_mux = ch_rdata[i];
        end
        if (key_sel) rd_mux = {24'b0, lock_val};
    end

    // Register read data on a read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end
endmodule

// File: rtl/pdma_regfile_chk.sv
// Property checker for pdma_regfile, attached by bind. It watches the
// host bus, the engine ports and the key byte, and flags protocol breaks.
module pdma_regfile_chk
    import pdma_regs_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_wr,
    input logic                 host_rd,
    input logic [ADDR_W-1:0]    host_addr,
    input logic [DATA_W-1:0]    host_wdata,
    input logic [NCH*EVT_W-1:0] eng_evt,
    input logic [NCH-1:0]       eng_start,
    input logic [NCH-1:0]       eng_reset,
    input logic [NCH-1:0]       irq,
    input logic [NCH-1:0]       ch_err,
    input logic [7:0]           lock_val
);
    for (genvar i = 0; i < NCH; i++) begin : g_p
        localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(int'(CH_BASE) + i * CH_STRIDE);
        localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(int'(CH_BASE) + i * CH_STRIDE + 2);

        // R6: a start pulse requires the key to have held 7.
        p_start_keyed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[i] |-> ($past(lock_val) == KEY_VALUE));

        // R5: a start pulse follows a control write with go set and reset clear.
        p_start_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[i] |-> $past(host_wr && host_addr == CTL_A &&
                                   host_wdata[CTL_GO_BIT] && !host_wdata[CTL_RST_BIT]));

        // R4: a reset pulse follows a control write with the reset bit.
        p_reset_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            eng_reset[i] |-> $past(host_wr && host_addr == CTL_A && host_wdata[CTL_RST_BIT]));

        // R7: a status read with no new event leaves the channel quiet.
        p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd && host_addr == STAT_A && eng_evt[i*EVT_W +: EVT_W] == '0)
            |=> (!irq[i] && !ch_err[i]));

        // R9: an error event always raises the failure flag next cycle.
        p_err_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((eng_evt[i*EVT_W +: EVT_W] & STAT_ERR_MASK) != '0) |=> ch_err[i]);
    end
endmodule

bind pdma_regfile pdma_regfile_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .eng_evt    (eng_evt),
    .eng_start  (eng_start),
    .eng_reset  (eng_reset),
    .irq        (irq),
    .ch_err     (ch_err),
    .lock_val   (lock_val)
);

// File: tb/pdma_regfile_test.sv
// Self-checking bench for pdma_regfile: directed corner cases followed
// by seeded random traffic, all compared with a bench-side model.
`timescale 1ns/1ps
module pdma_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [15:0] eng_evt = '0;
    logic [1:0]  eng_start, eng_reset, irq, ch_err;
    logic [3:0]  cfg_pio;
    logic [31:0] cfg_pkt_cnt;
    logic [63:0] cfg_next_ptr;
    logic [31:0] cfg_fifo_in, cfg_fifo_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side model of the register state.
    logic        m_mask [2];
    logic [1:0]  m_pio  [2];
    logic [15:0] m_cnt  [2];
    logic [31:0] m_ptr  [2];
    logic [15:0] m_fin  [2];
    logic [15:0] m_fout [2];
    logic [7:0]  m_stat [2];
    logic [7:0]  m_key;

    always #2.5 clk = ~clk;

    pdma_regfile uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_evt(eng_evt), .eng_start(eng_start), .eng_reset(eng_reset),
        .irq(irq), .ch_err(ch_err), .cfg_pio(cfg_pio), .cfg_pkt_cnt(cfg_pkt_cnt),
        .cfg_next_ptr(cfg_next_ptr), .cfg_fifo_in(cfg_fifo_in), .cfg_fifo_out(cfg_fifo_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] base(input int ch);
        return 8'(8'h80 + ch * 8'h20);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'hC7) r = {24'b0, m_key};
        for (int ch = 0; ch < 2; ch++) begin
            if (a == base(ch))         r = {23'b0, m_mask[ch], 6'b0, m_pio[ch]};
            if (a == base(ch) + 8'h02) r = {24'b0, m_stat[ch]};
            if (a == base(ch) + 8'h04) r = {16'b0, m_cnt[ch]};
            if (a == base(ch) + 8'h0C) r = m_ptr[ch];
            if (a == base(ch) + 8'h14) r = {16'b0, m_fin[ch]};
            if (a == base(ch) + 8'h16) r = {16'b0, m_fout[ch]};
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int ch = 0; ch < 2; ch++) begin
            m_mask[ch] = 1'b1; m_pio[ch] = '0; m_cnt[ch] = 16'h1; m_ptr[ch] = '0;
            m_fin[ch] = 16'h100; m_fout[ch] = 16'h100; m_stat[ch] = '0;
        end
        m_key = '0;
    endtask

    // Compare every output derived from held state with the model.
    task automatic check_outputs(input string tag);
        for (int ch = 0; ch < 2; ch++) begin
            check(irq[ch] == (!m_mask[ch] && (m_stat[ch] != 0)), "R8 irq", 64'(irq), 64'(ch));
            check(ch_err[ch] == ((m_stat[ch] & 8'h51) != 0), "R9 ch_err", 64'(ch_err), 64'(m_stat[ch]));
            check(cfg_pio[ch*2 +: 2] == m_pio[ch], {tag, " R10 pio"}, 64'(cfg_pio[ch*2 +: 2]), 64'(m_pio[ch]));
            check(cfg_pkt_cnt[ch*16 +: 16] == m_cnt[ch], {tag, " R10 cnt"}, 64'(cfg_pkt_cnt[ch*16 +: 16]), 64'(m_cnt[ch]));
            check(cfg_next_ptr[ch*32 +: 32] == m_ptr[ch], {tag, " R10 ptr"}, 64'(cfg_next_ptr[ch*32 +: 32]), 64'(m_ptr[ch]));
            check(cfg_fifo_in[ch*16 +: 16] == m_fin[ch], {tag, " R10 fifo_in"}, 64'(cfg_fifo_in[ch*16 +: 16]), 64'(m_fin[ch]));
            check(cfg_fifo_out[ch*16 +: 16] == m_fout[ch], {tag, " R10 fifo_out"}, 64'(cfg_fifo_out[ch*16 +: 16]), 64'(m_fout[ch]));
        end
    endtask

    // One bus cycle, entered and left at a falling edge.
    task automatic bus(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] ev, input string tag);
        logic [31:0] exp_rd;
        logic [1:0]  exp_st = '0;
        logic [1:0]  exp_rs = '0;
        host_wr = w; host_rd = r; host_addr = a; host_wdata = d; eng_evt = ev;
        exp_rd = model_read(a);
        for (int ch = 0; ch < 2; ch++) begin
            if (w && a == base(ch)) begin
                if (d[5]) exp_rs[ch] = 1'b1;
                else if (d[7] && m_key == 8'h07) exp_st[ch] = 1'b1;
                m_mask[ch] = d[8]; m_pio[ch] = d[1:0];
            end
            if (w && a == base(ch) + 8'h04) m_cnt[ch]  = d[15:0];
            if (w && a == base(ch) + 8'h0C) m_ptr[ch]  = d;
            if (w && a == base(ch) + 8'h14) m_fin[ch]  = d[15:0];
            if (w && a == base(ch) + 8'h16) m_fout[ch] = d[15:0];
            if (r && a == base(ch) + 8'h02) m_stat[ch] = ev[ch*8 +: 8];
            else                            m_stat[ch] = m_stat[ch] | ev[ch*8 +: 8];
        end
        if (w && a == 8'hC7) m_key = d[7:0];
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; eng_evt = '0;
        if (r) check(host_rdata == exp_rd, {tag, " read"}, 64'(host_rdata), 64'(exp_rd));
        check(eng_reset == exp_rs, "R4 reset pulse", 64'(eng_reset), 64'(exp_rs));
        check(eng_start == exp_st, "R5 start pulse", 64'(eng_start), 64'(exp_st));
        check_outputs(tag);
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 8'h00, '0, '0, "idle");
        check(eng_start == 2'b00 && eng_reset == 2'b00, "R4 pulse single cycle",
              64'({eng_start, eng_reset}), 64'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs while and right after reset
        check_outputs("R1");
        check(eng_start == 0 && eng_reset == 0, "R1 pulses low", 64'({eng_start, eng_reset}), 64'h0);
        rst_n = 1'b1;
        for (int ch = 0; ch < 2; ch++) begin
            bus(0, 1, base(ch),         '0, '0, "R1 ctl");
            bus(0, 1, base(ch) + 8'h02, '0, '0, "R1 stat");
            bus(0, 1, base(ch) + 8'h04, '0, '0, "R1 cnt");
            bus(0, 1, base(ch) + 8'h0C, '0, '0, "R1 ptr");
            bus(0, 1, base(ch) + 8'h14, '0, '0, "R1 fin");
            bus(0, 1, base(ch) + 8'h16, '0, '0, "R1 fout");
        end
        bus(0, 1, 8'hC7, '0, '0, "R1 key");

        // R2: register map, widths and unmapped reads
        bus(1, 0, 8'hAC, 32'hDEAD_BEEF, '0, "R2");
        bus(1, 0, 8'h84, 32'h1234_5678, '0, "R2");
        bus(0, 1, 8'hAC, '0, '0, "R2 ptr ch1");
        bus(0, 1, 8'h84, '0, '0, "R2 cnt truncated");
        bus(1, 0, 8'h88, 32'hFFFF_FFFF, '0, "R2");
        bus(0, 1, 8'h88, '0, '0, "R2 unmapped");
        bus(0, 1, 8'h10, '0, '0, "R2 low hole");

        // R3: held fields and command bits reading 0
        bus(1, 0, 8'h80, 32'hFFFF_FE5F & 32'hFFFF_FF5B, '0, "R3");
        bus(0, 1, 8'h80, '0, '0, "R3 ctl readback");
        idle();

        // R6: start without the key is dropped
        bus(1, 0, 8'hA0, 32'h0000_0080, '0, "R6");
        check(eng_start == 2'b00, "R6 start while locked", 64'(eng_start), 64'h0);
        bus(1, 0, 8'hC7, 32'h0000_0005, '0, "R6");
        bus(0, 1, 8'hC7, '0, '0, "R6 key readback");
        bus(1, 0, 8'hA0, 32'h0000_0080, '0, "R6");
        check(eng_start == 2'b00, "R6 start with wrong key", 64'(eng_start), 64'h0);
        bus(1, 0, 8'hC7, 32'h0000_0007, '0, "R6");
        // R5: keyed start, and reset overriding start in one write
        bus(1, 0, 8'hA0, 32'h0000_0083, '0, "R5");
        check(eng_start == 2'b10, "R5 keyed start ch1", 64'(eng_start), 64'h2);
        idle();
        bus(1, 0, 8'h80, 32'h0000_00A0, '0, "R5 collision");
        check(eng_reset == 2'b01 && eng_start == 2'b00, "R5 reset wins",
              64'({eng_start, eng_reset}), 64'h1);

        // R7: sticky status, read-to-clear and same-cycle event
        bus(0, 0, 8'h00, '0, 16'h0010, "R7");
        bus(0, 1, 8'h82, '0, 16'h0040, "R7 read during event");
        bus(0, 1, 8'h82, '0, '0, "R7 event kept");
        bus(0, 1, 8'h82, '0, '0, "R7 cleared");
        bus(0, 0, 8'h00, '0, 16'h0200, "R7");
        bus(1, 0, 8'hA2, 32'hFFFF_FFFF, '0, "R7 write ignored");
        bus(0, 1, 8'hA2, '0, '0, "R7 status after write");

        // R8: mask gating
        bus(0, 0, 8'h00, '0, 16'h0002, "R8");
        bus(1, 0, 8'h80, 32'h0000_0000, '0, "R8 unmask");
        check(irq[0] == 1'b1, "R8 irq unmasked", 64'(irq), 64'h1);
        bus(1, 0, 8'h80, 32'h0000_0100, '0, "R8 mask");
        check(irq[0] == 1'b0, "R8 irq masked", 64'(irq), 64'h0);

        // Random traffic mixed over both channels.
        for (int n = 0; n < 600; n++) begin
            int ch;
            int sel;
            logic [7:0]  a;
            logic [31:0] d;
            logic [15:0] ev;
            bit w;
            ch  = int'($urandom % 2);
            sel = int'($urandom % 9);
            case (sel)
                0: a = base(ch);
                1: a = base(ch) + 8'h02;
                2: a = base(ch) + 8'h04;
                3: a = base(ch) + 8'h0C;
                4: a = base(ch) + 8'h14;
                5: a = base(ch) + 8'h16;
                6: a = base(ch) + 8'h1E;
                7: a = 8'hC7;
                default: a = base(ch) + 8'h02;
            endcase
            w = ($urandom % 2) == 1;
            d = $urandom;
            if (a == 8'hC7 && ($urandom % 2) == 1) d = 32'h7;
            ev[7:0]  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
            ev[15:8] = (($urandom % 4) == 0) ? 8'($urandom) : 8'h0;
            bus(w, !w, a, d, ev, "R2 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule